// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address that was not found in the translation cache. It fetches the mapping from page tables held in memory, so the translation work is done in hardware. A walk starts from a root register, `dir_base`, which gives the frame of the top-level directory. The walker fetches one directory word. If that word is marked present, it supplies the frame of a second-level table, and the walker fetches one word from that table. The virtual address is split as follows: bits 31:22 index the directory, bits 21:12 index the second-level table, and bits 11:0 pass through as the byte offset.

The result is returned as a single-cycle response. A successful walk returns the physical address and the raw leaf word, ready to be written into a translation cache. A failed walk returns a fault flag, together with the level at which the mapping was missing. Memory is reached through a simple read port. The port holds its request until the memory acknowledges it, so read latency may be any number of cycles.

Top module: `pt_walker`

## Requirements
- R1: After reset, `walk_ready` is 1, and `resp_valid` and `mem_rd_en` are 0.
- R2: The first read of a walk goes to `{dir_base[31:12], 12'h000} + vaddr[31:22]*4`. The low 12 bits of `dir_base` are ignored.
- R3: The second read goes to `{pde[31:12], 12'h000} + vaddr[21:12]*4`, where `pde` is the directory word returned by the first read.
- R4: Bit 0 of an entry is its present flag. If the directory word has bit 0 = 0, the walk ends with `resp_fault`=1 and `resp_fault_lvl`=0, after exactly one read.
- R5: If the table word has bit 0 = 0, the walk ends with `resp_fault`=1 and `resp_fault_lvl`=1, after exactly two reads.
- R6: On success, the walk makes exactly two reads and ends with `resp_fault`=0, `resp_pte` equal to the table word, and `resp_paddr` = `{pte[31:12], vaddr[11:0]}`.
- R7: `resp_valid` is high for exactly one cycle. In the following cycle, `walk_ready` is 1 again.
- R8: `walk_ready` is 0 from the cycle after a request is accepted until the response. A `walk_req`, `walk_vaddr` or `dir_base` change during that interval has no effect on the walk in progress.
- R9: While `mem_rd_en` is 1 and `mem_rd_ack` is 0, the request stays asserted and `mem_rd_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_base | input | 32 | Root register: directory frame in bits 31:12 |
| walk_req | input | 1 | Start a walk; accepted when `walk_ready` is 1 |
| walk_vaddr | input | 32 | Virtual address to translate |
| walk_ready | output | 1 | Walker idle and able to accept a request |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rd_ack | input | 1 | Memory returns `mem_rd_data` for the current request |
| mem_rd_data | input | 32 | Entry word read from memory |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_fault | output | 1 | 1 = translation failed |
| resp_fault_lvl | output | 1 | Faulting level: 0 = directory, 1 = table |
| resp_paddr | output | 32 | Physical address (valid when no fault) |
| resp_pte | output | 32 | Leaf entry word (valid when no fault) |

## Verification
The bench drives walks whose directory word is absent, walks whose leaf is absent, and walks that succeed. For each walk it counts the memory reads. A walker that does not stop on a missing directory word would make a second, spurious read from an address built from garbage. The bench sets the low bits of `dir_base` and changes the request inputs in the middle of a walk. A design that added the low bits into the root address, or re-sampled its inputs while busy, would fetch from the wrong address. Random memory latency checks that the request address stays steady until the acknowledge, and that the response pulse is exactly one cycle wide.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
   typedef enum logic [2:0] {
      WS_IDLE  = 3'd0,
      WS_DIR   = 3'd1,
      WS_PTE   = 3'd2,
      WS_DONE  = 3'd3,
      WS_FAULT = 3'd4
   } walk_state_e;

   localparam logic LVL_DIR = 1'b0;
   localparam logic LVL_TBL = 1'b1;
endpackage

// File: rtl/pt_walker_slot.sv
// Entry address: frame base plus the index scaled by the entry size.
module pt_walker_slot #(
   parameter int ADDR_W      = 32,
   parameter int OFF_W       = 12,
   parameter int IDX_W       = 10,
   parameter int ENTRY_BYTES = 4
) (
   input  logic [ADDR_W-OFF_W-1:0] frame,
   input  logic [IDX_W-1:0]        idx,
   output logic [ADDR_W-1:0]       addr
);
   localparam int ESH = $clog2(ENTRY_BYTES);

   logic [ADDR_W-1:0] base_w;
   logic [ADDR_W-1:0] off_w;

   assign base_w = {frame, {OFF_W{1'b0}}};
   assign off_w  = ADDR_W'(idx) << ESH;
   assign addr   = base_w + off_w;
endmodule

// File: rtl/pt_walker_fsm.sv
module pt_walker_fsm
   import pt_walker_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int OFF_W       = 12,
   parameter int PRESENT_BIT = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [ADDR_W-1:0]       vaddr,
   input  logic [ADDR_W-OFF_W-1:0] root_frame,
   input  logic                    mem_ack,
   input  logic [ADDR_W-1:0]       mem_data,
   output walk_state_e             state,
   output logic [ADDR_W-1:0]       va_q,
   output logic [ADDR_W-OFF_W-1:0] root_q,
   output logic [ADDR_W-OFF_W-1:0] pde_frame_q,
   output logic [ADDR_W-1:0]       pte_q,
   output logic                    lvl_q
);
   logic present;
   assign present = mem_data[PRESENT_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= WS_IDLE;
         va_q        <= '0;
         root_q      <= '0;
         pde_frame_q <= '0;
         pte_q       <= '0;
         lvl_q       <= LVL_DIR;
      end else begin
         unique case (state)
            WS_IDLE: if (start) begin
               va_q   <= vaddr;
               root_q <= root_frame;
               state  <= WS_DIR;
            end
            WS_DIR: if (mem_ack) begin
               if (present) begin
                  pde_frame_q <= mem_data[ADDR_W-1:OFF_W];
                  state       <= WS_PTE;
               end else begin
                  lvl_q <= LVL_DIR;
                  state <= WS_FAULT;
               end
            end
            WS_PTE: if (mem_ack) begin
               pte_q <= mem_data;
               if (present) begin
                  state <= WS_DONE;
               end else begin
                  lvl_q <= LVL_TBL;
                  state <= WS_FAULT;
               end
            end
            WS_DONE:  state <= WS_IDLE;
            WS_FAULT: state <= WS_IDLE;
            default:  state <= WS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pt_walker_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DIR_W       = 10,
   parameter int TBL_W       = 10,
   parameter int OFF_W       = 12,
   parameter int ENTRY_BYTES = 4,
   parameter int PRESENT_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] dir_base,
   input  logic              walk_req,
   input  logic [ADDR_W-1:0] walk_vaddr,
   output logic              walk_ready,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_ack,
   input  logic [ADDR_W-1:0] mem_rd_data,
   output logic              resp_valid,
   output logic              resp_fault,
   output logic              resp_fault_lvl,
   output logic [ADDR_W-1:0] resp_paddr,
   output logic [ADDR_W-1:0] resp_pte
);
   localparam int FRAME_W = ADDR_W - OFF_W;
   localparam int DIR_LSB = OFF_W + TBL_W;

   if (DIR_W + TBL_W + OFF_W != ADDR_W) begin : g_bad_split
      $error("pt_walker: index and offset widths must sum to ADDR_W");
   end
   if (ENTRY_BYTES < 1 || (ENTRY_BYTES & (ENTRY_BYTES - 1)) != 0) begin : g_bad_entry
      $error("pt_walker: ENTRY_BYTES must be a power of two");
   end
   if (PRESENT_BIT < 0 || PRESENT_BIT >= OFF_W) begin : g_bad_present
      $error("pt_walker: PRESENT_BIT must lie below the frame field");
   end

   walk_state_e         state;
   logic [ADDR_W-1:0]   va_q;
   logic [FRAME_W-1:0]  root_q;
   logic [FRAME_W-1:0]  pde_frame_q;
   logic [ADDR_W-1:0]   pte_q;
   logic                lvl_q;
   logic [ADDR_W-1:0]   dir_addr;
   logic [ADDR_W-1:0]   tbl_addr;
   logic                start;
   logic                unused_base_low;

   assign unused_base_low = ^dir_base[OFF_W-1:0];
   assign walk_ready      = (state == WS_IDLE);
   assign start           = walk_req && walk_ready;

   pt_walker_fsm #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .PRESENT_BIT(PRESENT_BIT)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .vaddr(walk_vaddr),
      .root_frame(dir_base[ADDR_W-1:OFF_W]),
      .mem_ack(mem_rd_ack), .mem_data(mem_rd_data),
      .state(state), .va_q(va_q), .root_q(root_q),
      .pde_frame_q(pde_frame_q), .pte_q(pte_q), .lvl_q(lvl_q)
   );

   pt_walker_slot #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(DIR_W), .ENTRY_BYTES(ENTRY_BYTES)
   ) u_dir_slot (
      .frame(root_q), .idx(va_q[ADDR_W-1:DIR_LSB]), .addr(dir_addr)
   );

   pt_walker_slot #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(TBL_W), .ENTRY_BYTES(ENTRY_BYTES)
   ) u_tbl_slot (
      .frame(pde_frame_q), .idx(va_q[DIR_LSB-1:OFF_W]), .addr(tbl_addr)
   );

   assign mem_rd_en      = (state == WS_DIR) || (state == WS_PTE);
   assign mem_rd_addr    = (state == WS_PTE) ? tbl_addr : dir_addr;
   assign resp_valid     = (state == WS_DONE) || (state == WS_FAULT);
   assign resp_fault     = (state == WS_FAULT);
   assign resp_fault_lvl = lvl_q;
   assign resp_pte       = pte_q;
   assign resp_paddr     = {pte_q[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]};
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
   parameter int ADDR_W      = 32,
   parameter int DIR_W       = 10,
   parameter int TBL_W       = 10,
   parameter int OFF_W       = 12,
   parameter int ENTRY_BYTES = 4,
   parameter int PRESENT_BIT = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] dir_base,
   input logic              walk_req,
   input logic [ADDR_W-1:0] walk_vaddr,
   input logic              walk_ready,
   input logic              mem_rd_en,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              mem_rd_ack,
   input logic [ADDR_W-1:0] mem_rd_data,
   input logic              resp_valid,
   input logic              resp_fault,
   input logic              resp_fault_lvl,
   input logic [ADDR_W-1:0] resp_paddr,
   input logic [ADDR_W-1:0] resp_pte
);
   localparam int ESH     = $clog2(ENTRY_BYTES);
   localparam int DIR_LSB = OFF_W + TBL_W;

   logic              dir_ph, tbl_ph;
   logic [ADDR_W-1:0] va_c, exp_dir, exp_tbl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_ph <= 1'b0; tbl_ph <= 1'b0;
         va_c <= '0; exp_dir <= '0; exp_tbl <= '0;
      end else begin
         if (walk_req && walk_ready) begin
            dir_ph  <= 1'b1;
            va_c    <= walk_vaddr;
            exp_dir <= {dir_base[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}
                     + (ADDR_W'(walk_vaddr[ADDR_W-1:DIR_LSB]) << ESH);
         end else if (dir_ph && mem_rd_en && mem_rd_ack) begin
            dir_ph  <= 1'b0;
            tbl_ph  <= mem_rd_data[PRESENT_BIT];
            exp_tbl <= {mem_rd_data[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}
                     + (ADDR_W'(va_c[DIR_LSB-1:OFF_W]) << ESH);
         end else if (tbl_ph && mem_rd_en && mem_rd_ack) begin
            tbl_ph <= 1'b0;
         end
      end
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      walk_ready |-> (!mem_rd_en && !resp_valid));

   assert_dir_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_ph && mem_rd_en) |-> (mem_rd_addr == exp_dir));

   assert_tbl_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_ph && mem_rd_en) |-> (mem_rd_addr == exp_tbl));

   assert_dir_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_ph && mem_rd_en && mem_rd_ack && !mem_rd_data[PRESENT_BIT])
      |=> (resp_valid && resp_fault && !resp_fault_lvl && !mem_rd_en));

   assert_tbl_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_ph && mem_rd_en && mem_rd_ack && !mem_rd_data[PRESENT_BIT])
      |=> (resp_valid && resp_fault && resp_fault_lvl));

   assert_leaf_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_fault) |->
      (resp_pte[PRESENT_BIT] && resp_paddr[OFF_W-1:0] == va_c[OFF_W-1:0]
       && resp_paddr[ADDR_W-1:OFF_W] == resp_pte[ADDR_W-1:OFF_W]));

   assert_resp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> (!resp_valid && walk_ready));

   assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req && walk_ready) |=> !walk_ready);

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && !mem_rd_ack) |=> (mem_rd_en && $stable(mem_rd_addr)));
endmodule

bind pt_walker pt_walker_chk #(
   .ADDR_W(ADDR_W), .DIR_W(DIR_W), .TBL_W(TBL_W), .OFF_W(OFF_W),
   .ENTRY_BYTES(ENTRY_BYTES), .PRESENT_BIT(PRESENT_BIT)
) u_chk (.*);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] dir_base = '0;
   logic        walk_req = 1'b0;
   logic [31:0] walk_vaddr = '0;
   logic        walk_ready;
   logic        mem_rd_en;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_ack = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic        resp_valid, resp_fault, resp_fault_lvl;
   logic [31:0] resp_paddr, resp_pte;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   pt_walker u_pt_walker (.*);

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      logic [31:0] x;
      x = a * 32'h9E3779B1;
      x = x ^ (x >> 15);
      x = x * 32'h85EBCA6B;
      x = x ^ (x >> 13);
      mem_word = {x[31:1], (x[6:5] != 2'b00)};
   endfunction

   // mode: 0 natural, 1 dir absent, 2 leaf absent, 3 both present
   task automatic do_walk(input logic [31:0] va, input logic [31:0] base,
                          input int mode, input bit poke);
      logic [31:0] pde, pte, exp_a, held;
      int nread, waitc, lat, it;
      bit busy_ok, hold_ok, waiting;
      pde = '0; pte = '0; nread = 0; waitc = 0; busy_ok = 1; hold_ok = 1;
      waiting = 0; held = '0;
      lat = $urandom_range(0, 3);
      @(negedge clk);
      chk(walk_ready == 1'b1, "R8 ready before request", 32'(walk_ready), 1);
      walk_vaddr = va; dir_base = base; walk_req = 1'b1;
      @(negedge clk);
      walk_req = poke;
      if (poke) begin walk_vaddr = ~va; dir_base = base ^ 32'h0123_4000; end
      for (it = 0; it < 64; it++) begin
         if (it > 0) @(negedge clk);
         mem_rd_ack = 1'b0;
         if (resp_valid) break;
         if (walk_ready) busy_ok = 0;
         if (mem_rd_en) begin
            if (waiting && mem_rd_addr != held) hold_ok = 0;
            waiting = 1; held = mem_rd_addr;
            if (waitc < lat) waitc++;
            else begin
               waitc = 0; waiting = 0; nread++;
               mem_rd_data = mem_word(mem_rd_addr);
               if (nread == 1) begin
                  exp_a = {base[31:12], 12'h000} + {20'd0, va[31:22], 2'b00};
                  chk(mem_rd_addr == exp_a, "R2 directory read address", mem_rd_addr, exp_a);
                  if (mode == 1) mem_rd_data[0] = 1'b0;
                  if (mode >= 2) mem_rd_data[0] = 1'b1;
                  pde = mem_rd_data;
               end else begin
                  exp_a = {pde[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
                  chk(mem_rd_addr == exp_a, "R3 table read address", mem_rd_addr, exp_a);
                  if (mode == 2) mem_rd_data[0] = 1'b0;
                  if (mode == 3) mem_rd_data[0] = 1'b1;
                  pte = mem_rd_data;
               end
               mem_rd_ack = 1'b1;
            end
         end
      end
      walk_req = 1'b0;
      chk(resp_valid == 1'b1, "R7 response arrives", 32'(resp_valid), 1);
      chk(busy_ok, "R8 ready low while busy", 32'(busy_ok), 1);
      chk(hold_ok, "R9 address held until ack", 32'(hold_ok), 1);
      if (!pde[0]) begin
         chk(resp_fault && !resp_fault_lvl, "R4 directory fault level 0",
             {30'd0, resp_fault, resp_fault_lvl}, 32'h2);
         chk(nread == 1, "R4 single read", 32'(nread), 1);
      end else if (!pte[0]) begin
         chk(resp_fault && resp_fault_lvl, "R5 table fault level 1",
             {30'd0, resp_fault, resp_fault_lvl}, 32'h3);
         chk(nread == 2, "R5 two reads", 32'(nread), 2);
      end else begin
         chk(!resp_fault, "R6 no fault", 32'(resp_fault), 0);
         chk(resp_pte == pte, "R6 leaf word", resp_pte, pte);
         exp_a = {pte[31:12], va[11:0]};
         chk(resp_paddr == exp_a, "R6 physical address", resp_paddr, exp_a);
         chk(nread == 2, "R6 two reads", 32'(nread), 2);
      end
      @(negedge clk);
      chk(!resp_valid && walk_ready, "R7 one-cycle pulse then ready",
          {30'd0, resp_valid, walk_ready}, 32'h1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(walk_ready && !resp_valid && !mem_rd_en, "R1 reset state",
          {29'd0, walk_ready, resp_valid, mem_rd_en}, 32'h4);
      rst_n = 1'b1;
      // directed corners
      do_walk(32'h0000_0000, 32'h0000_0000, 3, 0);
      do_walk(32'hFFFF_FFFF, 32'hABCD_EFFF, 3, 0);   // R2 low base bits ignored
      do_walk(32'h1111_1222, 32'h0040_0000, 1, 0);   // R4
      do_walk(32'hFFC0_0000, 32'h0080_0000, 2, 0);   // R5
      do_walk(32'h0030_2ABC, 32'h1234_5678, 3, 1);   // R8 mid-walk pokes ignored
      do_walk(32'hDEAD_BEEF, 32'h0000_1FFF, 1, 1);
      for (int k = 0; k < 150; k++) begin
         do_walk($urandom, $urandom, (k % 5 == 0) ? $urandom_range(0, 3) : 0,
                 ($urandom_range(0, 3) == 0));
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule